// File: doc/BRIEF.md
# Segmented Carry-Select Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a carry input and returns their sum and a carry output. The word is cut into segments of unequal width. The lowest segment is one full adder. Every segment above it runs two ripple chains side by side: one chain assumes its incoming carry is 0 and the other assumes it is 1. When the true carry arrives from the segment below, it drives a multiplexer. The multiplexer picks both the sum bits and the segment's carry-out from the two precomputed results. That carry-out then becomes the select line of the next segment up.

With the default 8-bit width the segment widths are 1, 3 and 4 bits, counted from the least significant end. For wider words the same rule continues: each segment is one bit wider than the one below it, and the last segment is trimmed to fit. This keeps the carry path growing roughly with the square root of the width instead of linearly.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and carry input, {carry_out, sum_out} equals op_a + op_b + carry_in, evaluated as a 9-bit unsigned value.
- R2: Bit 0 is produced by a single full adder. sum_out[0] equals op_a[0] ^ op_b[0] ^ carry_in, and the carry passed to bit 1 is the majority of those three bits.
- R3: Bits 1 to 3 form one 3-bit select segment. sum_out[3:1] equals the low 3 bits of op_a[3:1] + op_b[3:1] + (carry out of bit 0).
- R4: Bits 4 to 7 form one 4-bit select segment. sum_out[7:4] equals the low 4 bits of op_a[7:4] + op_b[7:4] + (carry out of bits 0 to 3).
- R5: Inside every select segment, the carry-1 chain result equals the carry-0 chain result plus one. At the ports, the 9-bit result with carry_in = 1 equals the result with carry_in = 0 plus one, for every operand pair.
- R6: carry_out is 1 exactly when op_a + op_b + carry_in is 256 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 8 | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The immediate assertions assume that the operands and carry input hold settled 0/1 values whenever the combinational logic is evaluated; they are not meant to judge transient states. The stimulus guarantees this. It changes the inputs only on the rising clock edge and reads the outputs at the falling edge, after the logic has settled. The stimulus also walks every one of the 2^17 input combinations, with carry_in varying fastest. That ordering lets each carry-0 result be compared directly against its carry-1 neighbour.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // nominal width of segment k: 1 bit at the bottom, then 3, 4, 5, ...
  function automatic int seg_nominal(input int k);
    return (k == 0) ? 1 : k + 2;
  endfunction

  // lowest bit index covered by segment k
  function automatic int seg_lo(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += seg_nominal(j);
    return acc;
  endfunction

  // number of segments needed to cover a word of w bits
  function automatic int seg_count(input int w);
    for (int n = 1; n < 64; n++) begin
      if (seg_lo(n) >= w) return n;
    end
    return 64;
  endfunction

  // actual width of segment k, trimmed at the top of the word
  function automatic int seg_width(input int k, input int w);
    int rem;
    rem = w - seg_lo(k);
    return (seg_nominal(k) < rem) ? seg_nominal(k) : rem;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

endpackage

// File: rtl/csel_full_adder_bit.sv
module csel_full_adder_bit
  import csel_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = fa_sum(x_i, y_i, c_i);
  assign c_o = fa_carry(x_i, y_i, c_i);
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] chain;
  assign chain[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csel_full_adder_bit u_fa (
      .x_i(x_i[i]),
      .y_i(y_i[i]),
      .c_i(chain[i]),
      .s_o(s_o[i]),
      .c_o(chain[i+1])
    );
  end

  assign c_o = chain[W];
endmodule

// File: rtl/csel_select_seg.sv
module csel_select_seg #(
  parameter int W = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  localparam int WP = W + 1;

  // the two speculative results, brought out for the assertions
  logic [W-1:0] sum_c0, sum_c1;
  logic         cy_c0, cy_c1;

  csel_ripple #(.W(W)) u_chain0 (
    .x_i(x_i), .y_i(y_i), .c_i(1'b0), .s_o(sum_c0), .c_o(cy_c0)
  );

  csel_ripple #(.W(W)) u_chain1 (
    .x_i(x_i), .y_i(y_i), .c_i(1'b1), .s_o(sum_c1), .c_o(cy_c1)
  );

  assign s_o = sel_i ? sum_c1 : sum_c0;
  assign c_o = sel_i ? cy_c1  : cy_c0;

  // R5
  always_comb begin
    pair_offset_chk: assert ({cy_c1, sum_c1} == {cy_c0, sum_c0} + WP'(1))
      else $error("carry-1 chain is not carry-0 chain plus one");
  end

  // R5
  always_comb begin
    pair_carry_chk: assert (!cy_c0 || cy_c1)
      else $error("carry-0 chain carries while carry-1 chain does not");
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int NSEG = seg_count(WIDTH);
  localparam int WP   = WIDTH + 1;

  // carry entering each segment; seg_carry[NSEG] leaves the word
  logic [NSEG:0] seg_carry;
  assign seg_carry[0] = carry_in;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int LO = seg_lo(k);
    localparam int SW = seg_width(k, WIDTH);
    if (k == 0) begin : g_low
      csel_full_adder_bit u_low (
        .x_i(op_a[0]),
        .y_i(op_b[0]),
        .c_i(seg_carry[0]),
        .s_o(sum_out[0]),
        .c_o(seg_carry[1])
      );
    end else begin : g_sel
      csel_select_seg #(.W(SW)) u_sel (
        .x_i(op_a[LO +: SW]),
        .y_i(op_b[LO +: SW]),
        .sel_i(seg_carry[k]),
        .s_o(sum_out[LO +: SW]),
        .c_o(seg_carry[k+1])
      );
    end
  end

  assign carry_out = seg_carry[NSEG];

  // R1
  always_comb begin
    total_sum_chk: assert ({carry_out, sum_out} == WP'(op_a) + WP'(op_b) + WP'(carry_in))
      else $error("segmented sum differs from arithmetic sum");
  end

  // R2
  always_comb begin
    low_carry_chk: assert (seg_carry[1] == ((op_a[0] & op_b[0]) | (op_a[0] & carry_in) | (op_b[0] & carry_in)))
      else $error("carry out of bit 0 is not the majority");
  end

  // R6
  always_comb begin
    top_carry_chk: assert (carry_out == ((int'(op_a) + int'(op_b) + int'(carry_in)) >= (1 << WIDTH)))
      else $error("carry_out disagrees with range of the sum");
  end
endmodule

// File: tb/tb_csel_adder.sv
module tb_csel_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk;
  logic       rst;
  logic [7:0] a, b;
  logic       ci;
  logic [7:0] s;
  logic       co;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  csel_adder dut (
    .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s), .carry_out(co)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d ci=%0d actual=%0d expected=%0d", req, a, b, ci, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int prev_total;
    rst = 1; a = 0; b = 0; ci = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // zero operands after start-up: R1 / R6
    check("R1", {co, s}, 0);
    check("R6", co, 0);
    prev_total = 0;
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          int total, c0, c3, got;
          @(posedge clk);
          a = ia[7:0]; b = ib[7:0]; ci = ic[0];
          @(negedge clk);
          total = ia + ib + ic;
          got = {23'd0, co, s};
          check("R1", got, total);
          // R2: bit 0 and its carry
          c0 = ((ia & 1) + (ib & 1) + ic) >> 1;
          check("R2", s[0], (ia ^ ib ^ ic) & 1);
          // R3: bits 1..3 with carry from bit 0
          check("R3", s[3:1], (((ia >> 1) & 7) + ((ib >> 1) & 7) + c0) & 7);
          // R4: bits 4..7 with carry out of bits 0..3
          c3 = ((ia & 15) + (ib & 15) + ic) >> 4;
          check("R4", s[7:4], (((ia >> 4) & 15) + ((ib >> 4) & 15) + c3) & 15);
          // R5: carry_in = 1 is one more than carry_in = 0
          if (ic == 1) check("R5", got, prev_total + 1);
          prev_total = got;
          // R6
          check("R6", co, (total >= 256) ? 1 : 0);
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule